// File: doc/BRIEF.md
# Subroutine Return Stack with Flag Packing

This block is the last-in-first-out stack that a small processor core uses for subroutine linkage. A call pushes one 32-bit word. That word holds the return address in its low bits, the carry flag in bit 31 and the zero flag in bit 30. A return pops the word and hands back the address and both flags. Separate push and pop operations move raw 32-bit words without changing them. Software can therefore save, inspect or rewrite the stored flag bits like any other data.

The newest entry sits in a top-of-stack register, and the older entries sit in a small synchronous memory. A pop presents the top word in the same cycle. The memory is read one cycle ahead of need, so a pop can be issued on every cycle. One read/write pointer addresses the memory and wraps freely. Nothing detects overflow or underflow: keeping the stack within its depth is the job of software. With the default of 8 memory words plus the top register, the stack holds 9 entries.

Top module: `cstk_top`

## Requirements
- R1: After reset, `top_o` reads 0. A pop issued as the first operation after reset returns 0 in that cycle.
- R2: A call (`op_i` = 3'b001) pushes the word {carry, zero, zeros, address}: bit 31 is `c_i`, bit 30 is `z_i`, bits 29..20 are zero and bits 19..0 are `ret_addr_i`. The word appears on `top_o` from the cycle after the call.
- R3: A push (`op_i` = 3'b011) stores all 32 bits of `push_data_i` unaltered. The value appears on `top_o` from the next cycle.
- R4: In the cycle a return (3'b010) or a pop (3'b100) is issued, the top entry is already on the outputs. `top_o` carries the whole word, `ret_addr_o` carries bits 19..0, `ret_c_o` carries bit 31 and `ret_z_o` carries bit 30. From the next cycle, `top_o` shows the entry that was below it.
- R5: Any mix of up to 9 calls and pushes is returned in exact reverse order, including by pops on consecutive cycles.
- R6: A raw pop of a word pushed by a call returns the packed flag bits intact. A return of a word stored by a raw push takes its flags from bits 31 and 30 and its address from bits 19..0, whatever bits 29..20 hold.
- R7: The pointer wraps modulo 8 with no detection. After 10 pushes v0..v9, ten pops return v9 down to v1 and then v8.
- R8: Codes 3'b000, 3'b101, 3'b110 and 3'b111 have no effect. `top_o` stays unchanged, and the stored entries are still popped in order afterwards.
- R9: A push directly followed by a pop, and a pop directly followed by a push, keep last-in-first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation: 000 idle, 001 call, 010 return, 011 push, 100 pop, others idle |
| ret_addr_i | input | 20 | Return address stored by a call |
| c_i | input | 1 | Carry flag stored by a call |
| z_i | input | 1 | Zero flag stored by a call |
| push_data_i | input | 32 | Raw word stored by a push |
| top_o | output | 32 | Current top-of-stack word |
| ret_addr_o | output | 20 | Address field of the top word |
| ret_c_o | output | 1 | Carry field (bit 31) of the top word |
| ret_z_o | output | 1 | Zero field (bit 30) of the top word |

## Verification
On every cycle, the assertions check the following:
- the pointer moves up by one on a call or push, down by one on a return or pop, and holds otherwise;
- an idle code leaves the top word still;
- a call or push is visible on the outputs one cycle later, with the flag and address fields in place;
- a push followed at once by a pop brings back the earlier top.

Only the bench scenarios can show the rest:
- true last-in-first-out order through the memory at every fill level;
- the read-ahead path during back-to-back pops;
- the wrap that overwrites old entries once the depth is exceeded.

// File: rtl/cstk_pkg.sv
`timescale 1ns/1ps
package cstk_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'b000,
    OP_CALL = 3'b001,
    OP_RET  = 3'b010,
    OP_PUSH = 3'b011,
    OP_POP  = 3'b100
  } cstk_op_e;

  // An operation that adds an entry
  function automatic logic op_adds(input logic [2:0] op);
    return (op == OP_CALL) || (op == OP_PUSH);
  endfunction

  // An operation that removes an entry
  function automatic logic op_removes(input logic [2:0] op);
    return (op == OP_RET) || (op == OP_POP);
  endfunction

endpackage

// File: rtl/cstk_codec.sv
`timescale 1ns/1ps
module cstk_codec #(
  parameter int WIDTH = 32,
  parameter int AW    = 20
) (
  input  logic [2:0]       op_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             c_i,
  input  logic             z_i,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] word_o
);
  import cstk_pkg::*;

  localparam int PAD = WIDTH - 2 - AW;

  // Carry in the top bit, zero just below, address at the bottom
  function automatic logic [WIDTH-1:0] pack_link(input logic [AW-1:0] a,
                                                 input logic c, input logic z);
    return {c, z, {PAD{1'b0}}, a};
  endfunction

  always_comb begin
    if (op_i == OP_CALL) word_o = pack_link(addr_i, c_i, z_i);
    else                 word_o = raw_i;
  end

endmodule

// File: rtl/cstk_ptr.sv
`timescale 1ns/1ps
module cstk_ptr #(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [PW-1:0] ptr_o,
  output logic [PW-1:0] rd_next_o
);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p,
                                         input logic up, input logic dn);
    if (up)      return p + 1'b1;
    else if (dn) return p - 1'b1;
    else         return p;
  endfunction

  assign ptr_d     = step(ptr_q, inc_i, dec_i);
  // The entry just below the top after this cycle
  assign rd_next_o = ptr_d - 1'b1;
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/cstk_ram.sv
`timescale 1ns/1ps
module cstk_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [PW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // One-cycle read; a same-cycle write to the read address is passed through
  always_ff @(posedge clk) begin
    if (!rst_n)                          rd_q <= '0;
    else if (we_i && waddr_i == raddr_i) rd_q <= wdata_i;
    else                                 rd_q <= mem[raddr_i];
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/cstk_top.sv
`timescale 1ns/1ps
module cstk_top #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int AW    = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [AW-1:0]    ret_addr_i,
  input  logic             c_i,
  input  logic             z_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] top_o,
  output logic [AW-1:0]    ret_addr_o,
  output logic             ret_c_o,
  output logic             ret_z_o
);
  import cstk_pkg::*;

  localparam int PW = $clog2(DEPTH);

  logic             push_ev;
  logic             pop_ev;
  logic [WIDTH-1:0] new_word;
  logic [PW-1:0]    ptr_q;
  logic [PW-1:0]    rd_next;
  logic [WIDTH-1:0] below_word;
  logic [WIDTH-1:0] top_q;

  assign push_ev = op_adds(op_i);
  assign pop_ev  = op_removes(op_i);

  cstk_codec #(.WIDTH(WIDTH), .AW(AW)) u_codec (
    .op_i  (op_i),
    .addr_i(ret_addr_i),
    .c_i   (c_i),
    .z_i   (z_i),
    .raw_i (push_data_i),
    .word_o(new_word)
  );

  cstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_i    (push_ev),
    .dec_i    (pop_ev),
    .ptr_o    (ptr_q),
    .rd_next_o(rd_next)
  );

  // A push spills the old top into the memory at the pointer
  cstk_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (push_ev),
    .waddr_i(ptr_q),
    .wdata_i(top_q),
    .raddr_i(rd_next),
    .rdata_o(below_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       top_q <= '0;
    else if (push_ev) top_q <= new_word;
    else if (pop_ev)  top_q <= below_word;
  end

  assign top_o      = top_q;
  assign ret_addr_o = top_q[AW-1:0];
  assign ret_c_o    = top_q[WIDTH-1];
  assign ret_z_o    = top_q[WIDTH-2];

endmodule

// File: rtl/cstk_chk.sv
`timescale 1ns/1ps
module cstk_chk #(
  parameter int WIDTH = 32,
  parameter int AW    = 20,
  parameter int PW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_i,
  input logic [AW-1:0]    ret_addr_i,
  input logic             c_i,
  input logic             z_i,
  input logic [WIDTH-1:0] push_data_i,
  input logic [WIDTH-1:0] top_o,
  input logic [AW-1:0]    ret_addr_o,
  input logic             ret_c_o,
  input logic             ret_z_o,
  input logic [PW-1:0]    ptr,
  input logic             push_ev,
  input logic             pop_ev
);
  import cstk_pkg::*;

  AST_CALL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CALL) |=> (ret_addr_o == $past(ret_addr_i) && ret_c_o == $past(c_i)
                           && ret_z_o == $past(z_i) && top_o[WIDTH-3:AW] == '0)); // R2

  AST_PUSH_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH) |=> (top_o == $past(push_data_i))); // R3

  AST_PTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> (ptr == PW'($past(ptr) + 1'b1))); // R7

  AST_PTR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> (ptr == PW'($past(ptr) - 1'b1))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ev && !pop_ev) |=> ($stable(top_o) && $stable(ptr))); // R8

  AST_PUSH_THEN_POP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(push_ev) && pop_ev) |=> (top_o == $past(top_o, 2))); // R9

endmodule

bind cstk_top cstk_chk #(.WIDTH(WIDTH), .AW(AW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_i       (op_i),
  .ret_addr_i (ret_addr_i),
  .c_i        (c_i),
  .z_i        (z_i),
  .push_data_i(push_data_i),
  .top_o      (top_o),
  .ret_addr_o (ret_addr_o),
  .ret_c_o    (ret_c_o),
  .ret_z_o    (ret_z_o),
  .ptr        (ptr_q),
  .push_ev    (push_ev),
  .pop_ev     (pop_ev)
);

// File: tb/cstk_top_test.sv
`timescale 1ns/1ps
module cstk_top_test;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'b000;
  logic [19:0] ret_addr_i = '0;
  logic        c_i = 1'b0;
  logic        z_i = 1'b0;
  logic [31:0] push_data_i = '0;
  logic [31:0] top_o;
  logic [19:0] ret_addr_o;
  logic        ret_c_o;
  logic        ret_z_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cstk_top #(.DEPTH(D), .WIDTH(32), .AW(20)) uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .ret_addr_i(ret_addr_i),
    .c_i(c_i), .z_i(z_i), .push_data_i(push_data_i), .top_o(top_o),
    .ret_addr_o(ret_addr_o), .ret_c_o(ret_c_o), .ret_z_o(ret_z_o)
  );

  function automatic logic [31:0] val(input int i);
    return (32'h9E3779B9 * (i + 1)) ^ {i[7:0], 24'h0};
  endfunction

  function automatic logic [31:0] link(input logic [19:0] a, input logic c, input logic z);
    return (32'(c) << 31) | (32'(z) << 30) | 32'(a);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_push(input logic [31:0] w);
    @(negedge clk); op_i = 3'b011; push_data_i = w; #1;
  endtask

  task automatic do_call(input logic [19:0] a, input logic c, input logic z);
    @(negedge clk); op_i = 3'b001; ret_addr_i = a; c_i = c; z_i = z; #1;
  endtask

  task automatic do_pop(input string req, input logic [31:0] exp);
    @(negedge clk); op_i = 3'b100; #1;
    check(req, top_o, exp);
  endtask

  task automatic do_ret(input string req, input logic [19:0] a, input logic c, input logic z);
    @(negedge clk); op_i = 3'b010; #1;
    check(req, {10'h0, ret_c_o, ret_z_o, ret_addr_o}, {10'h0, c, z, a});
  endtask

  task automatic peek(input string req, input logic [2:0] code, input logic [31:0] exp);
    @(negedge clk); op_i = code; #1;
    check(req, top_o, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset top", top_o, 32'h0);
    do_pop("R1 first pop", 32'h0);

    // R8: unused codes leave everything alone
    do_push(val(100));
    do_push(val(101));
    peek("R8 code000", 3'b000, val(101));
    peek("R8 code101", 3'b101, val(101));
    peek("R8 code110", 3'b110, val(101));
    peek("R8 code111", 3'b111, val(101));
    do_pop("R8 pop after idles", val(101));
    do_pop("R8 pop after idles", val(100));

    // R9: alternating push and pop
    do_push(val(1));
    do_pop("R9 push-pop", val(1));
    do_push(val(2));
    do_push(val(3));
    do_pop("R9 pop", val(3));
    do_push(val(4));
    do_pop("R9 pop after push", val(4));
    do_pop("R9 pop under", val(2));

    // R2/R4: every flag pair with several addresses
    for (int k = 0; k < 4; k++) begin
      do_call(20'h1 << (k * 5) | 20'(k * 3), k[1], k[0]);
      peek("R2 call word", 3'b000, link(20'h1 << (k * 5) | 20'(k * 3), k[1], k[0]));
    end
    for (int k = 3; k >= 0; k--)
      do_ret("R4 ret fields", 20'h1 << (k * 5) | 20'(k * 3), k[1], k[0]);

    // R6: raw access to flag bits
    do_call(20'hABCDE, 1'b1, 1'b0);
    do_pop("R6 raw pop of call", link(20'hABCDE, 1'b1, 1'b0));
    do_push(32'h4FF1_2345);
    do_ret("R6 ret of raw word", 20'h12345, 1'b0, 1'b1);
    do_push(32'hC000_0000);
    do_ret("R6 ret both flags", 20'h0, 1'b1, 1'b1);

    // R3/R5: every fill level, mixed calls and pushes, back-to-back pops
    for (int n = 1; n <= D + 1; n++) begin
      for (int i = 0; i < n; i++) begin
        if (i % 2 == 0) do_push(val(n * 16 + i));
        else do_call(val(n * 16 + i) & 20'hFFFFF, i[1], i[2]);
      end
      peek("R3 top after fill", 3'b000,
           ((n - 1) % 2 == 0) ? val(n * 16 + n - 1)
                              : link(val(n * 16 + n - 1) & 20'hFFFFF, (n - 1) & 2 ? 1'b1 : 1'b0,
                                     (n - 1) & 4 ? 1'b1 : 1'b0));
      for (int i = n - 1; i >= 0; i--) begin
        if (i % 2 == 0) do_pop("R5 lifo raw", val(n * 16 + i));
        else do_pop("R5 lifo call", link(val(n * 16 + i) & 20'hFFFFF, i[1], i[2]));
      end
    end

    // R7: wrap beyond capacity
    for (int i = 0; i < D + 2; i++) do_push(val(200 + i));
    for (int i = D + 1; i >= 1; i--) do_pop("R7 wrap order", val(200 + i));
    do_pop("R7 wrapped entry", val(200 + D));

    @(negedge clk); op_i = 3'b000;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule